// File: doc/BRIEF.md
# Buck Converter Gate Sequencer with Light-Load Pulse Skipping

This block is the digital core of a synchronous step-down converter. Once per switching period it decides how the high-side and low-side switch gates are driven. Its inputs are a one-clock oscillator pulse that marks each period and a set of comparator results that arrive already digitized. Two regimes are supported. In fixed-frequency PWM, every period starts with a high-side pulse that the current comparator ends, and the low side then conducts until the next period. In light-load skipping, pulses are short, end at a fixed current threshold, and stop whenever the output sits above its regulation band.

The block moves into skipping on its own after a run of periods in which the low-side current reached zero, provided the mode pin allows skipping. It drops back to PWM when the output sags below the band. When the feedback voltage shows a short circuit, only one oscillator pulse in three starts a period. Any change of gate ownership passes through a clock in which neither gate is on.

Top module: `buck_mode_ctrl`

## Requirements
- R1: In PWM mode, a period start (`cyc_start`) is followed by one clock with both gates off and then `hs_gate` high. After `pwm_trip`, one clock with both gates off is followed by `ls_gate` high, which holds until the next period start.
- R2: If `hs_gate` is still high when the next period starts, it goes low at that edge and rises again only after one clock with both gates off. The low side is not turned on in between.
- R3: `hs_gate` and `ls_gate` are never high together, and every rise of either gate follows a clock in which the other gate was low.
- R4: `ocp` high while `hs_gate` is high turns `hs_gate` off at the next clock edge, in either mode.
- R5: With `skip_sel` high, `skip_mode` rises at the period start that ends the ZC_RUN-th (default 8) consecutive period in which `zc_flag` was seen while `ls_gate` was high. In PWM mode, `ls_gate` stays on after `zc_flag`.
- R6: A period that ends without a zero crossing clears the run count, so skipping needs ZC_RUN fresh consecutive zero-cross periods after it.
- R7: In skip mode, `pwm_trip` does not end the high-side pulse, `skip_ilim` does. The low side then conducts until `zc_flag`, after which both gates stay off until the next period start.
- R8: In skip mode, `ov_band` turns `hs_gate` off at the next edge. Period starts then produce no pulse until `out_le_nom` has been seen high.
- R9: `uv_band` high in skip mode returns the block to PWM mode at the next edge.
- R10: With `skip_sel` low, `skip_mode` is 0 from the next edge on, whatever the zero-cross history.
- R11: While `scp` is high, only the first of every SC_DIV (default 3) `osc_tick` pulses produces `cyc_start`. With `scp` low, every `osc_tick` does.
- R12: With `en` low, both gates are off and `skip_mode` is 0 from the next edge on, and the zero-cross run count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Converter enable; low forces the gates off and resets the mode |
| osc_tick | input | 1 | One-clock pulse from the oscillator, once per switching period |
| skip_sel | input | 1 | High allows automatic skipping, low forces PWM |
| pwm_trip | input | 1 | Current-loop comparator has tripped |
| zc_flag | input | 1 | Low-side current has reached zero |
| skip_ilim | input | 1 | Sensed current has reached the skip pulse threshold |
| ocp | input | 1 | Overcurrent comparator |
| ov_band | input | 1 | Output is above the upper band edge |
| out_le_nom | input | 1 | Output is at or below nominal |
| uv_band | input | 1 | Output is below the lower band edge |
| scp | input | 1 | Feedback is below the short-circuit level |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |
| skip_mode | output | 1 | 1 while in skip mode |
| cyc_start | output | 1 | Period start after short-circuit division |

## Verification
PWM periods are run three ways: tripped normally, never tripped, and cut short by overcurrent. These separate comparator turn-off, the forced duty cap and the fast protection path. Zero-cross runs are applied unbroken, broken by one period, with the mode pin low, and across a disable. This shows that the count really needs consecutive periods and that it is cleared. In skip mode, a pulse that ends on the threshold is compared with one ended by overvoltage and with one ignored while the hold is in force. Tick trains with and without `scp` show the one-in-three division.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

   // Gate sequencer states; the gates are decoded from the state register
   typedef enum logic [2:0] {
      G_OFF = 3'd0,   // both gates off (disabled or skip idle)
      G_DTH = 3'd1,   // dead clock before the high side
      G_HS  = 3'd2,   // high side conducting
      G_DTL = 3'd3,   // dead clock before the low side
      G_LS  = 3'd4    // low side conducting
   } gate_st_e;

endpackage

// File: rtl/buck_cyc_div.sv
module buck_cyc_div #(
   parameter int SC_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic osc_tick,
   input  logic scp,
   output logic cyc_start
);

   generate
      if (SC_DIV < 1) begin : g_bad
         $error("SC_DIV must be at least 1");
      end

      if (SC_DIV > 1) begin : g_div
         localparam int DIV_W = $clog2(SC_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SC_DIV - 1);
         logic [DIV_W-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (!en || !scp) begin
               phase_q <= '0;
            end else if (osc_tick) begin
               phase_q <= (phase_q == DIV_LAST) ? '0 : phase_q + 1'b1;
            end
         end

         assign cyc_start = osc_tick && (!scp || (phase_q == '0));
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = scp ^ en ^ clk ^ rst_n;
         assign cyc_start  = osc_tick;
      end
   endgenerate

endmodule

// File: rtl/buck_zc_run.sv
module buck_zc_run #(
   parameter int ZC_RUN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic skip_sel,
   input  logic cyc_start,
   input  logic zc_flag,
   input  logic ls_gate,
   input  logic uv_band,
   output logic skip_mode
);

   localparam int CNT_W = $clog2(ZC_RUN);
   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(ZC_RUN - 1);

   generate
      if (ZC_RUN < 2) begin : g_bad
         $error("ZC_RUN must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] run_q;
   logic             seen_q;
   logic             zc_now;

   assign zc_now = zc_flag && ls_gate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= '0;
         seen_q    <= 1'b0;
         skip_mode <= 1'b0;
      end else if (!en || !skip_sel) begin
         run_q     <= '0;
         seen_q    <= 1'b0;
         skip_mode <= 1'b0;
      end else if (skip_mode) begin
         run_q  <= '0;
         seen_q <= 1'b0;
         if (uv_band) skip_mode <= 1'b0;
      end else if (cyc_start) begin
         seen_q <= 1'b0;
         if (seen_q || zc_now) begin
            if (run_q == RUN_LAST) begin
               run_q     <= '0;
               skip_mode <= 1'b1;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end else if (zc_now) begin
         seen_q <= 1'b1;
      end
   end

   // R5
   skip_entry_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(skip_mode) |-> $past(cyc_start));

   // R9
   uv_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_mode && uv_band |=> !skip_mode);

endmodule

// File: rtl/buck_gate_fsm.sv
module buck_gate_fsm
   import buck_mode_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic cyc_start,
   input  logic skip_mode,
   input  logic pwm_trip,
   input  logic skip_ilim,
   input  logic zc_flag,
   input  logic ocp,
   input  logic ov_band,
   input  logic out_le_nom,
   output logic hs_gate,
   output logic ls_gate
);

   gate_st_e st_q, st_d;
   logic     hold_q;
   logic     start_ok;
   logic     hs_end;

   // a period start opens a pulse unless skipping is holding off
   assign start_ok = cyc_start && !(skip_mode && (hold_q || ov_band));
   assign hs_end   = ocp || (skip_mode ? (skip_ilim || ov_band) : pwm_trip);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         G_OFF: if (start_ok) st_d = G_DTH;
         G_DTH: st_d = G_HS;
         G_HS: begin
            if (hs_end)        st_d = G_DTL;
            else if (cyc_start) st_d = start_ok ? G_DTH : G_DTL;
         end
         G_DTL: st_d = G_LS;
         G_LS: begin
            if (start_ok)                  st_d = G_DTH;
            else if (skip_mode && zc_flag) st_d = G_OFF;
         end
         default: st_d = G_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= G_OFF;
         hold_q <= 1'b0;
      end else if (!en) begin
         st_q   <= G_OFF;
         hold_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (!skip_mode)      hold_q <= 1'b0;
         else if (ov_band)    hold_q <= 1'b1;
         else if (out_le_nom) hold_q <= 1'b0;
      end
   end

   assign hs_gate = (st_q == G_HS);
   assign ls_gate = (st_q == G_LS);

   // R3
   ls_dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate) |-> $past(!hs_gate));

   // R3
   hs_dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate) |-> $past(!ls_gate));

   // R8
   ov_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_gate && skip_mode && ov_band |=> !hs_gate);

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl #(
   parameter int ZC_RUN = 8,
   parameter int SC_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic osc_tick,
   input  logic skip_sel,
   input  logic pwm_trip,
   input  logic zc_flag,
   input  logic skip_ilim,
   input  logic ocp,
   input  logic ov_band,
   input  logic out_le_nom,
   input  logic uv_band,
   input  logic scp,
   output logic hs_gate,
   output logic ls_gate,
   output logic skip_mode,
   output logic cyc_start
);

   buck_cyc_div #(.SC_DIV(SC_DIV)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .osc_tick  (osc_tick),
      .scp       (scp),
      .cyc_start (cyc_start)
   );

   buck_zc_run #(.ZC_RUN(ZC_RUN)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .skip_sel  (skip_sel),
      .cyc_start (cyc_start),
      .zc_flag   (zc_flag),
      .ls_gate   (ls_gate),
      .uv_band   (uv_band),
      .skip_mode (skip_mode)
   );

   buck_gate_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .cyc_start  (cyc_start),
      .skip_mode  (skip_mode),
      .pwm_trip   (pwm_trip),
      .skip_ilim  (skip_ilim),
      .zc_flag    (zc_flag),
      .ocp        (ocp),
      .ov_band    (ov_band),
      .out_le_nom (out_le_nom),
      .hs_gate    (hs_gate),
      .ls_gate    (ls_gate)
   );

   // R4
   ocp_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_gate && ocp |=> !hs_gate);

   // R10
   forced_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !skip_sel |=> !skip_mode);

   // R12
   disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!hs_gate && !ls_gate && !skip_mode));

endmodule

// File: tb/buck_mode_ctrl_bench.sv
module buck_mode_ctrl_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, osc_tick = 1'b0, skip_sel = 1'b1, pwm_trip = 1'b0;
   logic zc_flag = 1'b0, skip_ilim = 1'b0, ocp = 1'b0, ov_band = 1'b0;
   logic out_le_nom = 1'b0, uv_band = 1'b0, scp = 1'b0;
   logic hs_gate, ls_gate, skip_mode, cyc_start;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   buck_mode_ctrl u_buck_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .osc_tick(osc_tick),
      .skip_sel(skip_sel), .pwm_trip(pwm_trip), .zc_flag(zc_flag),
      .skip_ilim(skip_ilim), .ocp(ocp), .ov_band(ov_band),
      .out_le_nom(out_le_nom), .uv_band(uv_band), .scp(scp),
      .hs_gate(hs_gate), .ls_gate(ls_gate), .skip_mode(skip_mode),
      .cyc_start(cyc_start)
   );

   task automatic check(input logic act, input logic exp, input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic tick();
      osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
   endtask

   // one PWM period: pulse, trip, low side, optional zero crossing
   task automatic pwm_period(input logic with_zc);
      tick();
      step();
      pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
      step();
      if (with_zc) begin
         zc_flag = 1'b1; step(); zc_flag = 1'b0;
      end
      repeat (3) step();
   endtask

   task automatic t_reset();
      check(hs_gate, 1'b0, "R12", "hs after reset");
      check(ls_gate, 1'b0, "R12", "ls after reset");
      check(skip_mode, 1'b0, "R12", "skip after reset");
   endtask

   task automatic t_pwm_r1();
      tick();
      check(hs_gate | ls_gate, 1'b0, "R3", "dead clock before hs");
      step();
      check(hs_gate, 1'b1, "R1", "hs on");
      pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
      check(hs_gate | ls_gate, 1'b0, "R3", "dead clock before ls");
      step();
      check(ls_gate, 1'b1, "R1", "ls on after trip");
      repeat (5) step();
      check(ls_gate & !hs_gate, 1'b1, "R1", "ls held to period end");
   endtask

   task automatic t_cap_r2();
      tick(); step();
      check(hs_gate, 1'b1, "R2", "hs on");
      repeat (6) step();
      check(hs_gate, 1'b1, "R2", "hs still on without trip");
      tick();
      check(hs_gate | ls_gate, 1'b0, "R2", "hs forced off, no ls");
      step();
      check(hs_gate & !ls_gate, 1'b1, "R2", "next pulse");
      pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
      step();
   endtask

   task automatic t_ocp_r4();
      tick(); step();
      check(hs_gate, 1'b1, "R4", "hs on");
      ocp = 1'b1; step(); ocp = 1'b0;
      check(hs_gate | ls_gate, 1'b0, "R4", "hs cut by overcurrent");
      step();
      check(ls_gate, 1'b1, "R4", "ls after overcurrent");
      repeat (2) step();
   endtask

   task automatic t_break_r6();
      for (int i = 0; i < 7; i++) pwm_period(1'b1);
      pwm_period(1'b0);
      for (int i = 0; i < 7; i++) pwm_period(1'b1);
      tick();
      check(skip_mode, 1'b0, "R6", "broken run does not enter skip");
      step();
      pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
      repeat (3) step();
   endtask

   task automatic enter_skip();
      for (int i = 0; i < 8; i++) pwm_period(1'b1);
      tick();
   endtask

   task automatic t_enter_r5();
      tick(); step();
      pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
      step();
      zc_flag = 1'b1; step(); zc_flag = 1'b0;
      check(ls_gate, 1'b1, "R5", "ls stays on after zero cross in PWM");
      repeat (2) step();
      for (int i = 0; i < 7; i++) pwm_period(1'b1);
      check(skip_mode, 1'b0, "R5", "no skip before eighth period ends");
      tick();
      check(skip_mode, 1'b1, "R5", "skip entered");
   endtask

   task automatic t_skip_r7();
      step();
      check(hs_gate, 1'b1, "R7", "skip pulse on");
      pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
      check(hs_gate, 1'b1, "R7", "pwm trip ignored in skip");
      skip_ilim = 1'b1; step(); skip_ilim = 1'b0;
      check(hs_gate | ls_gate, 1'b0, "R7", "hs off at skip threshold");
      step();
      check(ls_gate, 1'b1, "R7", "ls on");
      zc_flag = 1'b1; step(); zc_flag = 1'b0;
      check(hs_gate | ls_gate, 1'b0, "R7", "idle after zero cross");
      repeat (3) step();
      check(hs_gate | ls_gate | !skip_mode, 1'b0, "R7", "idle held");
   endtask

   task automatic t_hold_r8();
      tick(); step();
      check(hs_gate, 1'b1, "R8", "pulse on");
      ov_band = 1'b1; step(); ov_band = 1'b0;
      check(hs_gate, 1'b0, "R8", "hs cut by overvoltage");
      step();
      zc_flag = 1'b1; step(); zc_flag = 1'b0;
      tick(); step(); step();
      check(hs_gate | ls_gate, 1'b0, "R8", "no pulse while holding");
      out_le_nom = 1'b1; step(); out_le_nom = 1'b0;
      tick(); step();
      check(hs_gate, 1'b1, "R8", "pulses resume at nominal");
      skip_ilim = 1'b1; step(); skip_ilim = 1'b0;
      step();
      zc_flag = 1'b1; step(); zc_flag = 1'b0;
   endtask

   task automatic t_exit_r9();
      uv_band = 1'b1; step(); uv_band = 1'b0;
      check(skip_mode, 1'b0, "R9", "skip left on undervoltage");
      tick(); step();
      pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
      check(hs_gate, 1'b0, "R9", "pwm trip ends pulse again");
      repeat (3) step();
   endtask

   task automatic t_sel_r10();
      skip_sel = 1'b0;
      for (int i = 0; i < 9; i++) pwm_period(1'b1);
      tick();
      check(skip_mode, 1'b0, "R10", "no skip with select low");
      step();
      pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
      repeat (2) step();
      skip_sel = 1'b1;
      enter_skip();
      check(skip_mode, 1'b1, "R10", "skip entered with select high");
      skip_sel = 1'b0; step();
      check(skip_mode, 1'b0, "R10", "select low leaves skip");
      pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
      repeat (3) step();
      skip_sel = 1'b1;
   endtask

   task automatic t_scp_r11();
      scp = 1'b1;
      for (int i = 0; i < 4; i++) begin
         osc_tick = 1'b1; #1;
         check(cyc_start, (i == 0 || i == 3), "R11", $sformatf("divided start, tick %0d", i));
         @(negedge clk); osc_tick = 1'b0;
         step();
         check(hs_gate, (i == 0 || i == 3), "R11", $sformatf("pulse on tick %0d", i));
         pwm_trip = 1'b1; step(); pwm_trip = 1'b0;
         repeat (2) step();
      end
      scp = 1'b0;
      for (int i = 0; i < 2; i++) begin
         osc_tick = 1'b1; #1;
         check(cyc_start, 1'b1, "R11", "undivided start");
         @(negedge clk); osc_tick = 1'b0;
         repeat (4) step();
      end
   endtask

   task automatic t_en_r12();
      enter_skip();
      step();
      check(hs_gate & skip_mode, 1'b1, "R12", "in skip pulse before disable");
      en = 1'b0; step();
      check(hs_gate | ls_gate | skip_mode, 1'b0, "R12", "disable clears gates and mode");
      tick(); step(); step();
      check(hs_gate | ls_gate, 1'b0, "R12", "no pulse while disabled");
      en = 1'b1; step();
      for (int i = 0; i < 7; i++) pwm_period(1'b1);
      tick();
      check(skip_mode, 1'b0, "R12", "run count cleared by disable");
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      en = 1'b1;
      step();
      t_pwm_r1();
      t_cap_r2();
      t_ocp_r4();
      t_break_r6();
      t_enter_r5();
      t_skip_r7();
      t_hold_r8();
      t_exit_r9();
      t_sel_r10();
      t_scp_r11();
      t_en_r12();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule